// File: doc/BRIEF.md
# Sync-Realigned Integer Clock Divider

This block produces a clock-enable strobe from its input clock once every N cycles. N is a programmed ratio from 1 up to a parameterised maximum. A sync input from another clock domain can restart the divider phase, so that several dividers can be brought into a common alignment. The sync input is passed through a flop synchroniser. Each rising edge on it becomes a single internal event, and each accepted event clears the divide counter.

Two control bits must both be set before any sync event is allowed to reach the divider: a master permit and a divider permit. A third bit selects the one-shot mode. In one-shot mode, the first event that gets through realigns the divider, and the divider permit then drops by itself, so later events have no effect. With the one-shot bit clear, every event that gets through realigns the divider. Software writes the control bits and the ratio through a simple register write port, and it can read the control bits back at any time.

Top module: `sdiv_clkdiv_sync`

## Requirements
- R1: After reset the control readback is 0x00, the ratio is N=1, and from the second clock after reset release `div_ce` is high on every cycle.
- R2: A write with `reg_sel`=0 loads the control bits: bit 0 is the master permit, bit 1 is the divider permit and bit 2 is the one-shot select. `ctrl_rdata` returns these three bits in the same positions, and bits 7 to 3 always read 0 whatever was written.
- R3: A write with `reg_sel`=1 sets the ratio to N = `reg_wdata[2:0]` + 1. When running freely, `div_ce` is high for one cycle in every N.
- R4: A sync event has no effect on `div_ce` while control bit 0 is 0.
- R5: A sync event has no effect on `div_ce` while control bit 1 is 0.
- R6: With bits 1 and 0 set and bit 2 clear, every sync event is accepted. At an accepted event the counter restarts, `div_ce` is low in the cycle that follows, and it is next high exactly N cycles after that.
- R7: With bits 2, 1 and 0 all set, the first sync event is accepted and bit 1 reads 0 from the next cycle on. Later events are ignored.
- R8: If a control write and a one-shot self-clear fall in the same cycle, the written value is what is kept.
- R9: A rise on `sync_in` is accepted at the third clock edge after it, counting the two synchroniser edges. A pulse held high for many cycles gives only one event, and its falling edge gives none.
- R10: If the ratio is lowered below the current count, the counter wraps with a `div_ce` pulse at the next edge, and it then runs at the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous sync request, rising edge active |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = control bits, 1 = ratio |
| reg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control bit readback |
| div_ce | output | 1 | Divided clock enable strobe |

## Verification
A register write is visible on `ctrl_rdata` right after the clock edge that takes it. A rise on `sync_in` is accepted at the third edge after it is driven. At that edge `div_ce` drops and the one-shot permit clears, and the next strobe follows N edges later. The bench drives its inputs just after a rising edge and keeps a tick count from a known aligning sync. For every cycle in a window it predicts the strobe pattern from that count, N and the planned pulse times, and it compares at that same point after each edge. A sync that is ignored is detected because, had it been applied, it would have moved or suppressed a predicted strobe.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Bit positions of the control fields in the readback and write word
   localparam int CTRL_MASTER_POS  = 0;
   localparam int CTRL_DIVEN_POS   = 1;
   localparam int CTRL_ONESHOT_POS = 2;
   localparam int CTRL_BITS        = 3;

   // Write target select values
   localparam logic SEL_CTRL  = 1'b0;
   localparam logic SEL_RATIO = 1'b1;

   typedef struct packed {
      logic oneshot;
      logic div_en;
      logic master;
   } sdiv_ctrl_t;

endpackage

// File: rtl/sdiv_sync_edge.sv
module sdiv_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   localparam int CHAIN_W = STAGES + 1;

   logic [CHAIN_W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdiv_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= async_in;
   end

   genvar gi;
   generate
      for (gi = 1; gi < CHAIN_W; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= 1'b0;
            else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   // the last stage only holds the previous synchronised level
   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R9
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/sdiv_ctrl_regs.sv
module sdiv_ctrl_regs
   import sdiv_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 3,
   parameter int DIV_MAX = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sync_evt,
   output logic [CNT_W-1:0]  ratio_m1,
   output logic              accept,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [CNT_W-1:0] RATIO_TOP = CNT_W'(DIV_MAX - 1);

   sdiv_ctrl_t       ctrl_q;
   logic             ctrl_wr;
   logic             ratio_wr;
   logic [CNT_W-1:0] ratio_code;

   assign ctrl_wr  = we && (sel == SEL_CTRL);
   assign ratio_wr = we && (sel == SEL_RATIO);

   // a sync event passes only through both permits
   assign accept = sync_evt & ctrl_q.master & ctrl_q.div_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.master  <= wdata[CTRL_MASTER_POS];
         ctrl_q.div_en  <= wdata[CTRL_DIVEN_POS];
         ctrl_q.oneshot <= wdata[CTRL_ONESHOT_POS];
      end else if (accept && ctrl_q.oneshot) begin
         ctrl_q.div_en <= 1'b0;
      end
   end

   // ratio code width depends on whether DIV_MAX fills the counter range
   generate
      if (DIV_MAX == (1 << CNT_W)) begin : g_ratio_full
         assign ratio_code = wdata[CNT_W-1:0];
      end else begin : g_ratio_clip
         assign ratio_code = (wdata[CNT_W-1:0] > RATIO_TOP) ? RATIO_TOP
                                                            : wdata[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ratio_m1 <= '0;
      else if (ratio_wr) ratio_m1 <= ratio_code;
   end

   generate
      if (DATA_W > CTRL_BITS) begin : g_rd_pad
         assign rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
      end else begin : g_rd_exact
         assign rdata = ctrl_q;
      end
   endgenerate

   // R7
   oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ctrl_q.oneshot && !ctrl_wr) |=> !ctrl_q.div_en);

   // R8
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (rdata[CTRL_BITS-1:0] == $past(wdata[CTRL_BITS-1:0])));

   // R5
   permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.div_en && !ctrl_wr) |=> !ctrl_q.div_en);

endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ratio_m1,
   input  logic             realign,
   output logic             ce
);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   // >= so that a ratio lowered below the count still wraps at once
   assign wrap = (cnt >= ratio_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ce  <= 1'b0;
      end else if (realign) begin
         cnt <= '0;
         ce  <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         ce  <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
         ce  <= 1'b0;
      end
   end

   // R6
   realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> (!ce && cnt == '0));

   // R3
   ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && ratio_m1 != '0) |=> !ce);

   // R10
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > ratio_m1) |=> (cnt == '0));

endmodule

// File: rtl/sdiv_clkdiv_sync.sv
module sdiv_clkdiv_sync #(
   parameter int DATA_W      = 8,
   parameter int DIV_MAX     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] ctrl_rdata,
   output logic              div_ce
);

   localparam int CNT_W = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

   generate
      if (DIV_MAX < 2) begin : g_bad_div
         $error("sdiv_clkdiv_sync: DIV_MAX must be at least 2");
      end
      if (DATA_W < sdiv_pkg::CTRL_BITS || DATA_W < CNT_W) begin : g_bad_data
         $error("sdiv_clkdiv_sync: DATA_W too narrow for control or ratio");
      end
   endgenerate

   logic             sync_evt;
   logic             accept;
   logic [CNT_W-1:0] ratio_m1;

   sdiv_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_in),
      .rise     (sync_evt)
   );

   sdiv_ctrl_regs #(
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .DIV_MAX (DIV_MAX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .sync_evt (sync_evt),
      .ratio_m1 (ratio_m1),
      .accept   (accept),
      .rdata    (ctrl_rdata)
   );

   sdiv_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_m1 (ratio_m1),
      .realign  (accept),
      .ce       (div_ce)
   );

   // R4
   master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_evt && !ctrl_rdata[sdiv_pkg::CTRL_MASTER_POS]) |-> !accept);

endmodule

// File: tb/sdiv_clkdiv_sync_test.sv
module sdiv_clkdiv_sync_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] ctrl_rdata;
   logic       div_ce;

   int checks = 0;
   int errors = 0;
   int t = 0;
   int sync_fall = -1;

   always #2.5 clk = ~clk;

   sdiv_clkdiv_sync uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_in    (sync_in),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .ctrl_rdata (ctrl_rdata),
      .div_ce     (div_ce)
   );

   task automatic tick();
      @(posedge clk);
      #1;
      t++;
      if (t == sync_fall) sync_in = 1'b0;
   endtask

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at t=%0d: actual %0h expected %0h", req, t, act, exp);
      end
   endtask

   task automatic wr(logic sel, logic [7:0] data);
      reg_we = 1'b1;
      reg_sel = sel;
      reg_wdata = data;
      tick();
      reg_we = 1'b0;
   endtask

   // strobes at first, first+n, ...; checked for ticks start..stop
   task automatic expect_train(int start, int first, int n, int stop, string req);
      while (t < stop) begin
         tick();
         if (t >= start)
            check(req, int'(div_ce),
                  int'(t >= first && ((t - first) % n) == 0));
      end
   endtask

   task automatic fire_sync(int width);
      sync_in = 1'b1;
      sync_fall = t + width;
   endtask

   // align with an accepted sync in continuous mode; returns at t=3+2N
   task automatic align(int code);
      int n = code + 1;
      wr(1'b1, 8'(code));
      wr(1'b0, 8'h03);
      tick();
      tick();
      t = 0;
      fire_sync(1);
      expect_train(3, 3 + n, n, 3 + 2 * n, "R6 align");
   endtask

   task automatic test_reset();
      tick();
      check("R1 ctrl", int'(ctrl_rdata), 'h00);
      for (int i = 0; i < 4; i++) begin
         tick();
         check("R1 ce", int'(div_ce), 1);
      end
   endtask

   task automatic test_ctrl_rw();
      wr(1'b0, 8'hFF);
      check("R2 ff", int'(ctrl_rdata), 'h07);
      wr(1'b0, 8'hA5);
      check("R2 a5", int'(ctrl_rdata), 'h05);
      wr(1'b0, 8'h00);
      check("R2 00", int'(ctrl_rdata), 'h00);
   endtask

   task automatic test_ratio();
      align(0);
      expect_train(6, 4, 1, 10, "R3 n1");
      align(4);
      expect_train(14, 8, 5, 20, "R3 n5");
      fire_sync(1);
      expect_train(21, 28, 5, 36, "R6 resync");
   endtask

   task automatic test_master_gate();
      align(4);
      wr(1'b0, 8'h02);
      fire_sync(1);
      expect_train(15, 18, 5, 30, "R4");
   endtask

   task automatic test_div_gate();
      align(4);
      wr(1'b0, 8'h05);
      fire_sync(1);
      expect_train(15, 18, 5, 30, "R5");
   endtask

   task automatic test_oneshot();
      align(4);
      wr(1'b0, 8'h07);
      fire_sync(1);
      expect_train(15, 22, 5, 16, "R7");
      check("R7 before", int'(ctrl_rdata), 'h07);
      expect_train(17, 22, 5, 17, "R7");
      check("R7 cleared", int'(ctrl_rdata), 'h05);
      expect_train(18, 22, 5, 24, "R7");
      fire_sync(1);
      expect_train(25, 22, 5, 34, "R7 ignored");
      check("R7 stays", int'(ctrl_rdata), 'h05);
   endtask

   task automatic test_collision();
      align(4);
      wr(1'b0, 8'h07);
      fire_sync(1);
      expect_train(15, 22, 5, 16, "R8");
      wr(1'b0, 8'h07);
      check("R8 ce", int'(div_ce), 0);
      check("R8 ctrl", int'(ctrl_rdata), 'h07);
      expect_train(18, 22, 5, 24, "R8");
      fire_sync(1);
      expect_train(25, 32, 5, 33, "R8 next");
      check("R8 cleared", int'(ctrl_rdata), 'h05);
   endtask

   task automatic test_long_pulse();
      align(4);
      fire_sync(17);
      expect_train(14, 21, 5, 38, "R9");
   endtask

   task automatic test_shrink();
      align(7);
      while (t < 24) tick();
      wr(1'b1, 8'h02);
      check("R10 hold", int'(div_ce), 0);
      expect_train(26, 26, 3, 33, "R10");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      test_reset();
      test_ctrl_rw();
      test_ratio();
      test_master_gate();
      test_div_gate();
      test_oneshot();
      test_collision();
      test_long_pulse();
      test_shrink();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule